// File: doc/BRIEF.md
# Lockable Escalating Watchdog Timer

This block supervises software through a timeout counter that advances on a one-cycle base tick strobe. Software writes an 8-bit configuration register through a write strobe. The register holds an enable, a lock, a timeout exponent and an escalation selector. Software keeps the watchdog quiet by writing the service bit (bit 7) with the opposite of the last value it accepted. If the counter reaches 2^n ticks with no valid service, the block issues a one-cycle MCU reset pulse. It counts these watchdog resets when they happen back to back. Once the count reaches the number chosen by the selector, the MCU reset pulse is also flagged as a system reset.

Setting the lock bit freezes bits 6:0 until the next power-on reset. The service bit keeps working while the lock is set. The block is built around one state machine with three states:
- OFF: the watchdog is disabled. The counter is held at zero.
- RUN: the block counts ticks.
- FIRE: a one-cycle state that drives the reset pulse.

Its transitions are:
- OFF to RUN when enable is set.
- RUN to OFF when enable is cleared.
- RUN to RUN with a restarted count on a valid service.
- RUN to FIRE on the expiring tick.
- FIRE to RUN, or FIRE to OFF, depending on enable.

A separate escalation counter tracks the back-to-back watchdog resets.

Top module: `wdt_lockdog`

## Requirements
- R1: After power-on reset `rd_data` reads 0x80 (expected next service value 1, all fields zero) and neither reset output is high.
- R2: `rd_data` bit 7 gives the expected next service value. Bits 6:5 are the escalation selector, bits 4:2 the timeout exponent n, bit 1 the lock and bit 0 the enable. Each write to an unlocked register stores bits 6:0.
- R3: With enable at 1 and no service, `mcu_rst` is high for exactly one cycle, starting in the cycle after the 2^n-th tick since the count last restarted.
- R4: A write whose bit 7 differs from the last accepted service value is a valid service. It restarts the count at zero and inverts the expected next value shown on `rd_data` bit 7.
- R5: A write whose bit 7 equals the last accepted service value neither restarts the count nor changes `rd_data` bit 7.
- R6: The escalation selector works as follows. With 00, `sys_rst` is never asserted. With 01, it is asserted with every watchdog reset. With 10, it is asserted with the 4th back-to-back watchdog reset. With 11, it is asserted with the 8th.
- R7: With enable at 0, no reset pulse occurs whatever the ticks. A change of enable from 0 to 1 starts the count from zero.
- R8: A valid service clears the count of back-to-back watchdog resets.
- R9: The back-to-back count returns to zero after it triggers a system reset.
- R10: Once the lock bit is 1, it stays 1, and writes leave bits 6:0 unchanged until power-on reset.
- R11: While locked, bit 7 of a write is still accepted as a service.
- R12: A valid service written in the same cycle as the expiring tick wins. No reset is issued, and the count restarts.
- R13: The configuration survives watchdog resets. Power-on reset clears the configuration, the lock and the back-to-back count.
- R14: `sys_rst` is high only in a cycle where `mcu_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write value |
| tick | input | 1 | One-cycle base period strobe |
| rd_data | output | 8 | Expected service value and configuration readback |
| mcu_rst | output | 1 | One-cycle watchdog MCU reset pulse |
| sys_rst | output | 1 | One-cycle escalated system reset pulse |

## Verification
A service write and the expiring tick can arrive on the same clock edge. The bench drives the register write and the tick strobe in the same cycle, with the timeout at one tick. It then judges the result by the absence of any reset pulse, and by a reset that appears only one full period after that edge. Two other events can also share a cycle: a system reset escalation and its MCU reset. The scoreboard checks each MCU reset pulse for the system flag predicted from the selector and the back-to-back count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int WDG_DATA_W  = 8;
    localparam int WDG_PS_W    = 3;
    localparam int WDG_SEL_W   = 2;
    localparam int WDG_CNT_W   = 1 << WDG_PS_W;
    localparam int WDG_ESC_W   = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdg_state_e;

    typedef struct packed {
        logic [WDG_SEL_W-1:0] esc_sel;
        logic [WDG_PS_W-1:0]  ps;
        logic                 lock;
        logic                 en;
    } wdg_cfg_t;
endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  wr_en,
    input  logic [WDG_DATA_W-1:0] wr_data,
    output wdg_cfg_t              cfg,
    output logic                  svc,
    output logic [WDG_DATA_W-1:0] rd_data
);
    wdg_cfg_t cfg_q;
    logic     last_clr_q;

    always_comb begin
        svc     = wr_en && (wr_data[WDG_DATA_W-1] != last_clr_q);
        cfg     = cfg_q;
        rd_data = {~last_clr_q, cfg_q};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q      <= '0;
            last_clr_q <= 1'b0;
        end else begin
            if (svc)
                last_clr_q <= wr_data[WDG_DATA_W-1];
            if (wr_en && !cfg_q.lock)
                cfg_q <= wdg_cfg_t'(wr_data[WDG_DATA_W-2:0]);
        end
    end

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock |=> cfg_q.lock);
    a_r10_fields_frozen: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock |=> $stable(cfg_q));
    a_r4_service_toggles: assert property (@(posedge clk) disable iff (!por_n)
        svc |=> (last_clr_q != $past(last_clr_q)));
    a_r5_repeat_keeps: assert property (@(posedge clk) disable iff (!por_n)
        !svc |=> $stable(last_clr_q));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int PS_W  = WDG_PS_W,
    parameter int CNT_W = 1 << PS_W
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    input  logic            tick,
    input  logic            svc,
    output logic            expire,
    output logic            mcu_rst
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_tick;

    always_comb last_tick = (ONE << ps) - ONE;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (svc) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == last_tick) begin
                        expire  = 1'b1;
                        state_d = ST_FIRE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_FIRE: begin
                cnt_d   = '0;
                state_d = en ? ST_RUN : ST_OFF;
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb mcu_rst = (state_q == ST_FIRE);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        mcu_rst |=> !mcu_rst);
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= last_tick);
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !mcu_rst) |=> !mcu_rst);
    a_r12_service_wins: assert property (@(posedge clk) disable iff (!por_n)
        svc |=> !mcu_rst);
endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator
    import wdg_pkg::*;
#(
    parameter int SEL_W = WDG_SEL_W,
    parameter int ESC_W = WDG_ESC_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             svc,
    input  logic             expire,
    output logic             hit
);
    localparam logic [ESC_W-1:0] ONE   = ESC_W'(1);
    localparam logic [ESC_W-1:0] SAT   = {ESC_W{1'b1}};
    localparam logic [ESC_W-1:0] THR_1 = ESC_W'(1);
    localparam logic [ESC_W-1:0] THR_4 = ESC_W'(4);
    localparam logic [ESC_W-1:0] THR_8 = ESC_W'(8);

    logic [ESC_W-1:0] esc_q, thr;
    logic             hit_q;

    always_comb begin
        unique case (sel)
            2'b01:   thr = THR_1;
            2'b10:   thr = THR_4;
            2'b11:   thr = THR_8;
            default: thr = '0;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            esc_q <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (svc) begin
                esc_q <= '0;
            end else if (expire) begin
                if ((thr != '0) && (esc_q + ONE >= thr)) begin
                    esc_q <= '0;
                    hit_q <= 1'b1;
                end else if (esc_q != SAT) begin
                    esc_q <= esc_q + ONE;
                end
            end
        end
    end

    always_comb hit = hit_q;

    a_r8_service_clears: assert property (@(posedge clk) disable iff (!por_n)
        svc |=> (esc_q == '0));
    a_r9_hit_clears: assert property (@(posedge clk) disable iff (!por_n)
        hit_q |-> (esc_q == '0));
    a_r14_hit_from_expiry: assert property (@(posedge clk) disable iff (!por_n)
        hit_q |-> $past(expire));
endmodule

// File: rtl/wdt_lockdog.sv
module wdt_lockdog
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tick,
    output logic [7:0] rd_data,
    output logic       mcu_rst,
    output logic       sys_rst
);
    wdg_cfg_t cfg;
    logic     svc, expire, esc_hit, mcu_pulse;

    wdg_cfg_reg u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .svc     (svc),
        .rd_data (rd_data)
    );

    wdg_timer #(.PS_W(WDG_PS_W)) u_timer (
        .clk     (clk),
        .por_n   (por_n),
        .en      (cfg.en),
        .ps      (cfg.ps),
        .tick    (tick),
        .svc     (svc),
        .expire  (expire),
        .mcu_rst (mcu_pulse)
    );

    wdg_escalator #(.SEL_W(WDG_SEL_W), .ESC_W(WDG_ESC_W)) u_esc (
        .clk    (clk),
        .por_n  (por_n),
        .sel    (cfg.esc_sel),
        .svc    (svc),
        .expire (expire),
        .hit    (esc_hit)
    );

    always_comb begin
        mcu_rst = mcu_pulse;
        sys_rst = mcu_pulse && esc_hit;
    end

    a_r14_sys_with_mcu: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |-> mcu_rst);
    a_r14_hit_aligned: assert property (@(posedge clk) disable iff (!por_n)
        esc_hit |-> mcu_pulse);
endmodule

// File: tb/wdt_lockdog_tb_top.sv
module wdt_lockdog_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic [7:0] rd_data;
    logic       mcu_rst, sys_rst;

    int checks = 0;
    int fails = 0;
    bit exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_lockdog dut_i (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_data(rd_data), .mcu_rst(mcu_rst), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // driver: pushes the expected system flag, then supplies the expiring tick
    task automatic expect_rst(input bit sys);
        exp_q.push_back(sys);
        ticks(1);
    endtask

    task automatic queue_empty(input string req);
        chk(req, exp_q.size(), 0);
    endtask

    // monitor: every reset pulse must match an expected item
    always @(negedge clk) begin
        if (por_n && (mcu_rst || sys_rst)) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R3/R7 unexpected pulse actual mcu=%0b sys=%0b expected none",
                         mcu_rst, sys_rst);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk("R6/R14 pulse mcu", int'(mcu_rst), 1);
                chk("R6 pulse sys", int'(sys_rst), int'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", int'(rd_data), 8'h80);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", int'(rd_data), 8'h80);
        chk("R1 mcu_rst", int'(mcu_rst), 0);
        chk("R1 sys_rst", int'(sys_rst), 0);

        // R2 R4: valid service with enable, n=0
        wr(8'h81);
        chk("R2 readback", int'(rd_data), 8'h01);
        expect_rst(1'b0);                       // R3 n=0 -> 1 tick
        queue_empty("R3 n=0 pulse");
        chk("R13 cfg kept after watchdog reset", int'(rd_data), 8'h01);

        // n=2 -> 4 ticks
        wr(8'h09);
        chk("R2 readback n=2", int'(rd_data), 8'h89);
        ticks(3);
        expect_rst(1'b0);
        queue_empty("R3 n=2 pulse");

        // R5 repeated value is ignored
        ticks(2);
        wr(8'h09);
        chk("R5 expected value unchanged", int'(rd_data), 8'h89);
        ticks(1);
        expect_rst(1'b0);
        queue_empty("R5 no restart");

        // R4 valid service restarts
        ticks(3);
        wr(8'h89);
        chk("R4 expected value toggles", int'(rd_data), 8'h09);
        ticks(3);
        expect_rst(1'b0);
        queue_empty("R4 restart");

        // R7 disabled, then re-enable restarts
        ticks(2);
        wr(8'h08);
        ticks(10);
        queue_empty("R7 disabled quiet");
        wr(8'h89);
        ticks(3);
        expect_rst(1'b0);
        queue_empty("R7 re-enable restart");

        // R6 R9 selector 10 -> 4th reset
        wr(8'h41);
        for (int i = 0; i < 3; i++) expect_rst(1'b0);
        expect_rst(1'b1);
        expect_rst(1'b0);                       // R9 count restarted
        queue_empty("R6 sel 10 / R9");

        // R6 selector 01 -> every reset
        wr(8'hA1);
        expect_rst(1'b1);
        expect_rst(1'b1);
        queue_empty("R6 sel 01");

        // R6 selector 11 -> 8th reset
        wr(8'h61);
        for (int i = 0; i < 7; i++) expect_rst(1'b0);
        expect_rst(1'b1);
        queue_empty("R6 sel 11");

        // R8 service clears back-to-back count
        wr(8'hC1);
        for (int i = 0; i < 3; i++) expect_rst(1'b0);
        wr(8'h41);
        for (int i = 0; i < 3; i++) expect_rst(1'b0);
        expect_rst(1'b1);
        queue_empty("R8 service clears count");

        // R10 R11 lock
        wr(8'hC3);
        chk("R10 lock set readback", int'(rd_data), 8'h43);
        wr(8'h15);
        chk("R10 R11 fields frozen, service taken", int'(rd_data), 8'hC3);
        wr(8'h80);
        chk("R10 disable ignored when locked", int'(rd_data), 8'h43);
        expect_rst(1'b0);
        queue_empty("R10 still enabled");

        // R12 service on the expiring tick wins
        wr_tick(8'h13);
        chk("R12 service taken", int'(rd_data), 8'hC3);
        queue_empty("R12 no pulse");
        expect_rst(1'b0);
        queue_empty("R12 later expiry");

        // R13 power-on reset clears everything including lock
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        chk("R13 por readback", int'(rd_data), 8'h80);
        wr(8'h01);
        chk("R13 unlocked after por", int'(rd_data), 8'h81);
        expect_rst(1'b0);
        queue_empty("R13 runs after por");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule